// File: doc/BRIEF.md
# HDLC Receive Residue Code Tracker

This block runs beside a bit-oriented receiver whose frames may hold any number of bits between the opening and closing flags. That count need not be a whole number of characters. The block counts the accepted data bits modulo the programmed character length (5, 6, 7 or 8 bits). It samples that remainder when the closing flag is accepted and turns it into a 3-bit residue code. Software uses the code to find which right-justified bits of the final characters read from the receive FIFO are information bits and which belong to the 16-bit check sequence.

The code and an end-of-frame status bit do not pass through the data FIFO. Both update on the first character write into the FIFO after the closing flag, which is the frame's last character, even if older characters are still waiting to be read. Software may read the code only while end-of-frame is 1. The end-of-frame bit clears on a status read, or on the first character write of the next frame. The residue code keeps its value until the next frame updates it. A frame that is aborted before its closing flag changes neither output.

All inputs are single-cycle strobes or levels sampled on the rising clock edge. The receiver streams bits as strobes with no back-pressure: every strobe seen while a frame is open is counted, so the block can never stall the line. Status pins are plain levels.

Top module: `hdlc_residue_tracker`

## Requirements
- R1: After reset, eof_o is 0 and residue_o is 3'b000.
- R2: The remainder r equals N mod L. N is the number of bit_i strobes accepted after open_i and before the accepted close_i. L is set by len_sel_i: 2'b00=5, 2'b01=6, 2'b10=7, 2'b11=8 bits.
- R3: residue_o is the bit reversal of v = (r + 6) mod 8, written {v[0],v[1],v[2]}. For example, L=8 with r=3 gives 3'b100, and L=8 with r=0 gives 3'b011.
- R4: eof_o and residue_o change only on the first char_wr_i after an accepted close_i, and they are visible on the cycle after that write. Between close_i and that write, eof_o stays 0.
- R5: stat_rd_i clears eof_o on the next cycle. If it arrives in the same cycle as the write that sets eof_o, eof_o becomes 1.
- R6: The first char_wr_i after open_i clears eof_o on the next cycle, and residue_o keeps its previous value.
- R7: abort_i ends the open frame. A later char_wr_i then neither sets eof_o nor changes residue_o.
- R8: A char_wr_i that is neither the frame's first write nor the write after a closing flag leaves eof_o and residue_o unchanged.
- R9: close_i while no frame is open is ignored, so a following char_wr_i does not set eof_o.
- R10: A bit_i strobe in the same cycle as an accepted close_i is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| len_sel_i | input | 2 | Character length select (00=5 ... 11=8) |
| open_i | input | 1 | Opening flag seen; starts a frame and clears the bit count |
| bit_i | input | 1 | One accepted data bit (after zero deletion) |
| close_i | input | 1 | Closing flag seen |
| abort_i | input | 1 | Frame aborted |
| char_wr_i | input | 1 | A received character is written into the receive FIFO |
| stat_rd_i | input | 1 | Software reads the receive status |
| eof_o | output | 1 | End-of-frame status |
| residue_o | output | 3 | Residue code of the last completed frame |

## Verification
A remainder counter that is off by one, wraps at the wrong length or counts outside a frame produces a wrong residue_o. This shows up on the cycle after the frame's final write, so every frame length in the vector table exposes it at once. A stuck or mis-ordered pending flag shows as eof_o rising at the close instead of at the write, or not rising at all, one cycle after the strobe in question. A bad first-write tracker leaves eof_o high into the next frame, which is visible one cycle after that frame's first write.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
  typedef enum logic [1:0] {LEN5 = 2'b00, LEN6 = 2'b01, LEN7 = 2'b10, LEN8 = 2'b11} len_sel_e;

  // Character length in bits for a select value.
  function automatic logic [3:0] char_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/hrt_bit_counter.sv
module hrt_bit_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       len_sel_i,
  input  logic             open_i,
  input  logic             bit_i,
  input  logic             close_i,
  input  logic             abort_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             close_acc_o
);
  import hrt_pkg::*;

  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       len_m1;

  assign len_m1      = char_len(len_sel_i) - 4'd1;
  assign close_acc_o = close_i && in_frame_q && !open_i && !abort_i;
  assign rem_o       = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (open_i) begin
      in_frame_q <= 1'b1;
      cnt_q      <= '0;
    end else if (abort_i) begin
      in_frame_q <= 1'b0;
    end else if (close_i && in_frame_q) begin
      in_frame_q <= 1'b0;
    end else if (bit_i && in_frame_q) begin
      if (4'(cnt_q) >= len_m1) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: with no frame open, the count never moves
  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !open_i) |=> $stable(cnt_q));
  // R7: an abort closes the frame
  assert_abort_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !open_i) |=> !in_frame_q);
  // R10: the bit coincident with an accepted close is not counted
  assert_close_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_acc_o |=> $stable(cnt_q));
endmodule

// File: rtl/hrt_code_map.sv
module hrt_code_map #(
  parameter int CNT_W  = 3,
  parameter int CODE_W = 3,
  parameter int OFFSET = 6
) (
  input  logic [CNT_W-1:0]  rem_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] biased;

  assign biased = CODE_W'(rem_i) + CODE_W'(OFFSET);

  for (genvar g = 0; g < CODE_W; g++) begin : g_rev
    assign code_o[g] = biased[CODE_W-1-g];
  end
endmodule

// File: rtl/hrt_status.sv
module hrt_status #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_acc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              char_wr_i,
  input  logic              stat_rd_i,
  output logic              eof_o,
  output logic [CODE_W-1:0] residue_o
);
  logic              pend_q;
  logic [CODE_W-1:0] pend_code_q;
  logic              first_due_q;
  logic              set_eof;

  assign set_eof = char_wr_i && pend_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_code_q <= '0;
      first_due_q <= 1'b0;
      eof_o       <= 1'b0;
      residue_o   <= '0;
    end else begin
      if (close_acc_i) begin
        pend_q      <= 1'b1;
        pend_code_q <= code_i;
      end else if (set_eof) begin
        pend_q <= 1'b0;
      end

      if (open_i)         first_due_q <= 1'b1;
      else if (char_wr_i) first_due_q <= 1'b0;

      if (set_eof)                                   eof_o <= 1'b1;
      else if (stat_rd_i || (char_wr_i && first_due_q)) eof_o <= 1'b0;

      if (set_eof) residue_o <= pend_code_q;
    end
  end

  // R4: the write after a closing flag raises end-of-frame
  assert_eof_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_eof |=> eof_o);
  // R5: a status read without a coincident set clears end-of-frame
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !set_eof) |=> !eof_o);
  // R6: the code only moves on the frame's final write
  assert_code_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_eof |=> $stable(residue_o));
  // R4: end-of-frame never rises without that write
  assert_no_early_eof_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_eof |=> !$rose(eof_o));
endmodule

// File: rtl/hdlc_residue_tracker.sv
module hdlc_residue_tracker #(
  parameter int CNT_W  = 3,
  parameter int CODE_W = 3,
  parameter int OFFSET = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        len_sel_i,
  input  logic              open_i,
  input  logic              bit_i,
  input  logic              close_i,
  input  logic              abort_i,
  input  logic              char_wr_i,
  input  logic              stat_rd_i,
  output logic              eof_o,
  output logic [CODE_W-1:0] residue_o
);
  logic [CNT_W-1:0]  rem;
  logic              close_acc;
  logic [CODE_W-1:0] code;

  hrt_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .len_sel_i(len_sel_i), .open_i(open_i),
    .bit_i(bit_i), .close_i(close_i), .abort_i(abort_i),
    .rem_o(rem), .close_acc_o(close_acc)
  );

  hrt_code_map #(.CNT_W(CNT_W), .CODE_W(CODE_W), .OFFSET(OFFSET)) u_map (
    .rem_i(rem), .code_o(code)
  );

  hrt_status #(.CODE_W(CODE_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(open_i), .close_acc_i(close_acc),
    .code_i(code), .char_wr_i(char_wr_i), .stat_rd_i(stat_rd_i),
    .eof_o(eof_o), .residue_o(residue_o)
  );
endmodule

// File: tb/hdlc_residue_tracker_bench.sv
`timescale 1ns/1ps
module hdlc_residue_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] len_sel = 2'b11;
  logic       open_s = 1'b0, bit_s = 1'b0, close_s = 1'b0, abort_s = 1'b0;
  logic       wr_s = 1'b0, rd_s = 1'b0;
  logic       eof;
  logic [2:0] res;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hdlc_residue_tracker u_hdlc_residue_tracker (
    .clk_i(clk), .rst_ni(rst_n), .len_sel_i(len_sel), .open_i(open_s),
    .bit_i(bit_s), .close_i(close_s), .abort_i(abort_s), .char_wr_i(wr_s),
    .stat_rd_i(rd_s), .eof_o(eof), .residue_o(res)
  );

  // {len_sel, bit count}
  localparam logic [9:0] VEC [9] = '{
    {2'b11, 8'd19}, {2'b11, 8'd24}, {2'b11, 8'd31}, {2'b00, 8'd23},
    {2'b01, 8'd20}, {2'b10, 8'd30}, {2'b10, 8'd27}, {2'b00, 8'd20},
    {2'b01, 8'd17}};

  function automatic logic [2:0] exp_code(input logic [1:0] sel, input int n);
    int r, v;
    r = n % (5 + int'(sel));
    v = (r + 6) % 8;
    return {v[0], v[1], v[2]};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic open_bits(input logic [1:0] sel, input int n, input bit bit_on_close);
    @(negedge clk); len_sel = sel; open_s = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); open_s = 1'b0; bit_s = 1'b1;
    end
    @(negedge clk); open_s = 1'b0; bit_s = bit_on_close; close_s = 1'b1;
    @(negedge clk); bit_s = 1'b0; close_s = 1'b0;
  endtask

  task automatic pulse_wr(input bit with_rd);
    @(negedge clk); wr_s = 1'b1; rd_s = with_rd;
    @(negedge clk); wr_s = 1'b0; rd_s = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_s = 1'b1;
    @(negedge clk); rd_s = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check("R1 eof after reset", {3'b0, eof}, 4'd0);
    check("R1 residue after reset", {1'b0, res}, 4'd0);
    rst_n = 1'b1;

    // Vector table: R2 and R3 across lengths and remainders, R4 timing, R5 read.
    for (int k = 0; k < 9; k++) begin
      open_bits(VEC[k][9:8], int'(VEC[k][7:0]), 1'b0);
      check("R4 eof low between close and write", {3'b0, eof}, 4'd0);
      pulse_wr(1'b0);
      check("R4 eof set by final write", {3'b0, eof}, 4'd1);
      check("R2/R3 residue code", {1'b0, res}, {1'b0, exp_code(VEC[k][9:8], int'(VEC[k][7:0]))});
      pulse_rd();
      check("R5 status read clears eof", {3'b0, eof}, 4'd0);
    end

    // R6: first write of the next frame clears eof, code held.
    open_bits(2'b11, 19, 1'b0);
    pulse_wr(1'b0);
    check("R6 eof set before next frame", {3'b0, eof}, 4'd1);
    @(negedge clk); open_s = 1'b1;
    @(negedge clk); open_s = 1'b0;
    pulse_wr(1'b0);
    check("R6 first write clears eof", {3'b0, eof}, 4'd0);
    check("R6 residue held", {1'b0, res}, 4'b0100);

    // R7: abort, then a write: no eof, no code change.
    @(negedge clk); abort_s = 1'b1;
    @(negedge clk); abort_s = 1'b0;
    @(negedge clk); open_s = 1'b1;
    repeat (5) begin @(negedge clk); open_s = 1'b0; bit_s = 1'b1; end
    @(negedge clk); bit_s = 1'b0; abort_s = 1'b1;
    @(negedge clk); abort_s = 1'b0;
    pulse_wr(1'b0);
    check("R7 aborted frame no eof", {3'b0, eof}, 4'd0);
    check("R7 aborted frame code unchanged", {1'b0, res}, 4'b0100);

    // R8: stray write after eof set leaves outputs alone.
    open_bits(2'b11, 24, 1'b0);
    pulse_wr(1'b0);
    held = res;
    pulse_wr(1'b0);
    check("R8 stray write keeps eof", {3'b0, eof}, 4'd1);
    check("R8 stray write keeps code", {1'b0, res}, {1'b0, held});

    // R5 priority: read and setting write together.
    pulse_rd();
    open_bits(2'b11, 19, 1'b0);
    pulse_wr(1'b1);
    check("R5 set wins over read", {3'b0, eof}, 4'd1);
    pulse_rd();

    // R9: close outside a frame is ignored.
    @(negedge clk); close_s = 1'b1;
    @(negedge clk); close_s = 1'b0;
    pulse_wr(1'b0);
    check("R9 close outside frame no eof", {3'b0, eof}, 4'd0);

    // R10: bit together with close is not counted (18 bits, L=8 -> 000).
    open_bits(2'b11, 18, 1'b1);
    pulse_wr(1'b0);
    check("R10 coincident bit not counted", {1'b0, res}, {1'b0, exp_code(2'b11, 18)});

    summary();
    $finish;
  end
endmodule